// File: doc/BRIEF.md
# Serial Controller Interrupt Status Unit

This unit gathers the events of a serial bus controller and of its transmit and receive FIFOs into one 8-bit interrupt status register. It also holds a matching 8-bit enable mask and drives a single interrupt line. Some events are one-cycle pulses, such as a finished packet, a missing acknowledge or a lost arbitration. Others are levels: the two data-request conditions. Software reads the status register and clears bits by writing ones to them.

Two build options shape the unit. The first decides whether the packet-complete bit obeys its mask bit or always reaches the interrupt line. The second, a wrapper mode, adds a separate done-status register. Whenever the combined interrupt is active, that register's bit 30 is set. Software must clear it as well before the line drops.

Top module: `isu_intr_status`

## Requirements
- R1: During and after reset, the status register, the mask register and the done register all read zero, and `irq` is low.
- R2: A pulse on an event input sets its status bit at the next clock edge. The bit positions are: 7 packet complete, 6 all packets complete, 5 transmit overflow, 4 receive underflow, 3 missing acknowledge, 2 arbitration lost. A status bit stays set after its pulse ends.
- R3: A write to address 0 clears each status bit that is 1 in `reg_wdata[7:0]` and leaves every other status bit unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Bit 1 (transmit data request) and bit 0 (receive data request) are set on every edge at which their level input is high. A clear therefore does not hold while the level is high. Once the level is low, a clear sticks.
- R6: A write to address 1 loads the mask from `reg_wdata[7:0]`. Address 1 reads the mask back. Except as in R7, the core interrupt is the OR over all bits of status AND mask.
- R7: With `PKT_ALWAYS`=1, a set bit 7 drives the interrupt whatever mask bit 7 holds. With `PKT_ALWAYS`=0, bit 7 is gated by its mask bit like the other bits.
- R8: With `WRAP_EN`=1, the done bit (address 2, bit 30) is set at the edge after any cycle in which the core interrupt is active. `irq` is the core interrupt OR the done bit. Writing 1 to bit 30 at address 2 clears the done bit, unless the core interrupt is still active, in which case it is set again.
- R9: With `WRAP_EN`=0, address 2 reads zero and `irq` equals the core interrupt.
- R10: A write to address 3, or a write to the mask, leaves the status register unchanged. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 done, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pkt_done | input | 1 | Pulse: one packet finished |
| ev_all_done | input | 1 | Pulse: all packets finished |
| ev_tx_ovf | input | 1 | Pulse: transmit FIFO overflow |
| ev_rx_unf | input | 1 | Pulse: receive FIFO underflow |
| ev_nack | input | 1 | Pulse: acknowledge missing |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| lvl_tx_req | input | 1 | Level: transmit FIFO wants data |
| lvl_rx_req | input | 1 | Level: receive FIFO holds data |
| irq | output | 1 | Interrupt request |

## Verification
A clearing write to the status register and an event on the same bit can land in the same clock. So can a clearing write to the done bit and a still-active core interrupt. The bench provokes both: it raises the event input in the very cycle that the write strobe carries a one for that bit, and it clears the done bit while an enabled status bit is still set. The result is judged against a behavioural model that applies each clear first and each set after it, bit by bit, and the model is compared with the read data and `irq` of two differently built instances on every clock.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int EVT_W = 8;

  localparam int B_PKT_DONE = 7;
  localparam int B_ALL_DONE = 6;
  localparam int B_TX_OVF   = 5;
  localparam int B_RX_UNF   = 4;
  localparam int B_NACK     = 3;
  localparam int B_ARB_LOST = 2;
  localparam int B_TX_REQ   = 1;
  localparam int B_RX_REQ   = 0;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_DONE = 2'd2,
    A_RSVD = 2'd3
  } isu_addr_e;

  typedef logic [EVT_W-1:0] evt_vec_t;

  // Next status: clear first, then set, so a set always wins.
  function automatic evt_vec_t f_w1c_next(evt_vec_t cur, evt_vec_t set, evt_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  // Effective enable, with packet-complete optionally forced on.
  function automatic evt_vec_t f_eff_mask(evt_vec_t mask, bit pkt_always);
    evt_vec_t m;
    m = mask;
    if (pkt_always) m[B_PKT_DONE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/isu_evt_status.sv
module isu_evt_status
  import isu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_vec,
  input  evt_vec_t clr_vec,
  output evt_vec_t stat
);
  evt_vec_t stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= f_w1c_next(stat_q, set_vec, clr_vec);
  end

  assign stat = stat_q;

  // R4: every requested set is visible on the next edge, clear or not
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R3: a clear without a coincident set drops the bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));

  // R3: untouched bits hold their value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat_q ^ $past(stat_q)) & ~$past(set_vec | clr_vec)) == '0));
endmodule

// File: rtl/isu_irq_combine.sv
module isu_irq_combine
  import isu_pkg::*;
#(
  parameter bit PKT_ALWAYS = 1'b1
) (
  input  evt_vec_t stat,
  input  evt_vec_t mask,
  output evt_vec_t enabled,
  output logic     irq_core
);
  evt_vec_t eff;

  generate
    if (PKT_ALWAYS) begin : g_pkt_forced
      assign eff = f_eff_mask(mask, 1'b1);
    end else begin : g_pkt_masked
      assign eff = f_eff_mask(mask, 1'b0);
    end
  endgenerate

  assign enabled  = stat & eff;
  assign irq_core = |enabled;
endmodule

// File: rtl/isu_done_flag.sv
module isu_done_flag #(
  parameter bit WRAP_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_core,
  input  logic clr,
  output logic done
);
  logic done_q;
  logic set_now;

  assign set_now = WRAP_EN & irq_core;

  always_ff @(posedge clk) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (set_now) done_q <= 1'b1;
    else if (clr)     done_q <= 1'b0;
  end

  assign done = done_q;

  // R8: an active core interrupt raises the done flag one edge later
  p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> done_q);
endmodule

// File: rtl/isu_intr_status.sv
module isu_intr_status
  import isu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DONE_POS   = 30,
  parameter bit PKT_ALWAYS = 1'b1,
  parameter bit WRAP_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_pkt_done,
  input  logic              ev_all_done,
  input  logic              ev_tx_ovf,
  input  logic              ev_rx_unf,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic              lvl_tx_req,
  input  logic              lvl_rx_req,
  output logic              irq
);
  localparam int PAD_W = DATA_W - EVT_W;

  evt_vec_t set_vec, clr_vec, stat, mask_q, enabled;
  logic     wr_stat, wr_mask, wr_done, done_clr;
  logic     irq_core, done;
  logic     unused_wdata;

  assign wr_stat  = reg_we && (reg_addr == A_STAT);
  assign wr_mask  = reg_we && (reg_addr == A_MASK);
  assign wr_done  = reg_we && (reg_addr == A_DONE);
  assign done_clr = wr_done && reg_wdata[DONE_POS];
  assign clr_vec  = wr_stat ? reg_wdata[EVT_W-1:0] : '0;

  always_comb begin
    set_vec             = '0;
    set_vec[B_PKT_DONE] = ev_pkt_done;
    set_vec[B_ALL_DONE] = ev_all_done;
    set_vec[B_TX_OVF]   = ev_tx_ovf;
    set_vec[B_RX_UNF]   = ev_rx_unf;
    set_vec[B_NACK]     = ev_nack;
    set_vec[B_ARB_LOST] = ev_arb_lost;
    set_vec[B_TX_REQ]   = lvl_tx_req;
    set_vec[B_RX_REQ]   = lvl_rx_req;
  end

  assign unused_wdata = ^{reg_wdata[DATA_W-1:DONE_POS+1], reg_wdata[DONE_POS-1:EVT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[EVT_W-1:0];
  end

  isu_evt_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat    (stat)
  );

  isu_irq_combine #(.PKT_ALWAYS(PKT_ALWAYS)) u_combine (
    .stat     (stat),
    .mask     (mask_q),
    .enabled  (enabled),
    .irq_core (irq_core)
  );

  isu_done_flag #(.WRAP_EN(WRAP_EN)) u_done (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_core (irq_core),
    .clr      (done_clr),
    .done     (done)
  );

  assign irq = irq_core | done;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata = {{PAD_W{1'b0}}, stat};
      A_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
      A_DONE:  reg_rdata[DONE_POS] = done;
      default: reg_rdata = '0;
    endcase
  end

  // R6: no enabled status and no done flag means a quiet line
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((enabled == '0) && !done) |-> !irq);

  // R6: an enabled status bit always reaches the line
  p_irq_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & mask_q) != '0) |-> irq);

  // R7: packet-complete bypasses its mask when forced
  p_pkt_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (PKT_ALWAYS && stat[B_PKT_DONE]) |-> irq);

  // R8: a pending done flag holds the line high
  p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> irq);

  // R9: without the wrapper the done flag never rises
  p_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !WRAP_EN |-> !done);

  // R10: a mask or reserved write with no event leaves status alone
  p_status_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr != A_STAT) && (set_vec == '0)) |=> $stable(stat));
endmodule

// File: tb/isu_intr_status_tb.sv
module isu_intr_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  ev = '0;
  logic [31:0] rd_a, rd_b;
  logic        irq_a, irq_b;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference, index 0 = forced packet + wrapper, 1 = plain
  int m_stat [2];
  int m_mask [2];
  int m_done [2];
  bit m_always [2] = '{1'b1, 1'b0};
  bit m_wrap   [2] = '{1'b1, 1'b0};

  always #2 clk = ~clk;

  isu_intr_status #(.PKT_ALWAYS(1'b1), .WRAP_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_a),
    .ev_pkt_done(ev[7]), .ev_all_done(ev[6]), .ev_tx_ovf(ev[5]),
    .ev_rx_unf(ev[4]), .ev_nack(ev[3]), .ev_arb_lost(ev[2]),
    .lvl_tx_req(ev[1]), .lvl_rx_req(ev[0]), .irq(irq_a));

  isu_intr_status #(.PKT_ALWAYS(1'b0), .WRAP_EN(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_b),
    .ev_pkt_done(ev[7]), .ev_all_done(ev[6]), .ev_tx_ovf(ev[5]),
    .ev_rx_unf(ev[4]), .ev_nack(ev[3]), .ev_arb_lost(ev[2]),
    .lvl_tx_req(ev[1]), .lvl_rx_req(ev[0]), .irq(irq_b));

  function automatic bit m_core(int d);
    for (int i = 0; i < 8; i++) begin
      if (m_stat[d][i] && (m_mask[d][i] || (i == 7 && m_always[d]))) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit m_irq(int d);
    return m_core(d) || (m_done[d] != 0);
  endfunction

  function automatic int m_read(int d, int a);
    case (a)
      0: return m_stat[d];
      1: return m_mask[d];
      2: return m_done[d] ? (1 << 30) : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        m_stat[d] = 0; m_mask[d] = 0; m_done[d] = 0;
      end else begin
        bit core_now;
        int ns;
        core_now = m_core(d);
        ns = m_stat[d];
        for (int i = 0; i < 8; i++) begin
          if (ev[i]) ns |= (1 << i);
          else if (reg_we && reg_addr == 2'd0 && reg_wdata[i]) ns &= ~(1 << i);
        end
        if (m_wrap[d] && core_now) m_done[d] = 1;
        else if (reg_we && reg_addr == 2'd2 && reg_wdata[30]) m_done[d] = 0;
        if (reg_we && reg_addr == 2'd1) m_mask[d] = int'(reg_wdata[7:0]);
        m_stat[d] = ns;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!finished) begin
      check("u_dut irq",   int'(irq_a), int'(m_irq(0)));
      check("u_alt irq",   int'(irq_b), int'(m_irq(1)));
      check("u_dut rdata", int'(rd_a),  m_read(0, int'(reg_addr)));
      check("u_alt rdata", int'(rd_b),  m_read(1, int'(reg_addr)));
    end
  end

  task automatic wr(int a, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 32'(data);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic look(int a, int n);
    @(negedge clk);
    reg_addr = 2'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int bits);
    @(negedge clk);
    ev[7:2] = 6'(bits >> 2);
    @(negedge clk);
    ev[7:2] = '0;
  endtask

  task automatic quiesce();
    ev = '0;
    wr(1, 0);
    wr(0, 'hFF);
    wr(2, 1 << 30);
    wr(0, 'hFF);
    wr(2, 1 << 30);
    look(0, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) look(a, 2);

    // R2: every pulse event lands on its own bit
    cur_req = "R2";
    for (int i = 2; i < 8; i++) begin
      look(0, 1);
      pulse(1 << i);
      look(0, 2);
      wr(0, 1 << i);
      wr(2, 1 << 30);
    end
    pulse('hFC);
    look(0, 3);
    quiesce();

    // R3: partial clears keep other bits
    cur_req = "R3";
    pulse('hAC);
    wr(0, 'h28);
    look(0, 2);
    wr(0, 'h84);
    look(0, 2);
    quiesce();

    // R4: set and clear on the same bit in one cycle
    cur_req = "R4";
    pulse('h08);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h28; ev[5] = 1'b1; ev[3] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; ev = '0;
    look(0, 3);
    quiesce();

    // R5: level requests reassert while held
    cur_req = "R5";
    @(negedge clk); ev[1:0] = 2'b11;
    look(0, 2);
    wr(0, 'h03);
    look(0, 2);
    @(negedge clk); ev[1] = 1'b0;
    wr(0, 'h03);
    look(0, 3);
    @(negedge clk); ev[0] = 1'b0;
    wr(0, 'h01);
    look(0, 2);
    quiesce();

    // R6: mask gates the line
    cur_req = "R6";
    wr(1, 'h10);
    look(1, 2);
    pulse('h08);
    look(0, 3);
    pulse('h10);
    look(0, 3);
    wr(1, 'h5A);
    look(1, 2);
    quiesce();

    // R7: packet-complete forced on one build, masked on the other
    cur_req = "R7";
    pulse('h80);
    look(0, 3);
    wr(1, 'h80);
    look(0, 2);
    wr(1, 'h00);
    look(0, 2);
    quiesce();

    // R8: done flag, clear while core still active, then real clear
    cur_req = "R8";
    wr(1, 'h04);
    pulse('h04);
    look(2, 3);
    wr(2, 1 << 30);
    look(2, 2);
    wr(0, 'h04);
    look(2, 2);
    wr(2, 1 << 30);
    look(2, 2);
    quiesce();

    // R9: plain build has no done flag
    cur_req = "R9";
    wr(1, 'hFF);
    pulse('h40);
    look(2, 3);
    quiesce();

    // R10: mask and reserved writes leave status alone
    cur_req = "R10";
    pulse('h24);
    wr(3, 'hFF);
    look(3, 2);
    wr(1, 'hFF);
    look(0, 2);
    quiesce();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule